// File: doc/BRIEF.md
# Parallel Host Mailbox Bridge

The bridge joins an Intel-style host bus to a byte-wide peripheral port through two one-byte mailboxes. The host-to-peripheral mailbox (the input buffer, as seen from the peripheral) is loaded by a host write and drained by a peripheral read. The peripheral-to-host mailbox (the output buffer) is loaded by a peripheral write and drained by a host read. Two flags, `obuf_empty` and `ibuf_full`, tell the peripheral when it may send another byte and when a byte is waiting for it.

The host reaches the bridge with an active-low chip select, active-low read and write strobes and one address bit. Address 0 is the data mailbox and address 1 is status/control. Writing a 1 in bit 0 at address 1 sends a fixed-length active-low reset pulse to the peripheral and empties both mailboxes when the pulse ends. Writing into a mailbox that is still occupied sets an error line toward the peripheral and drops the byte. A host status read clears the error. All strobes are brought into the system clock and act once, on their falling edge.

Top module: `hostmbox_bridge`

## Requirements
- R1: After `rst_n` is released, `obuf_empty`=1, `ibuf_full`=0, `p_err_n`=1 and `p_reset_n`=1, and `p_data` is high impedance.
- R2: `p_data` carries the input-buffer byte whenever `p_sel`=1 and `p_rd_n`=0. In every other case it is high impedance. A read strobe with `p_sel`=0 neither drives the bus nor clears `ibuf_full`.
- R3: A falling edge of `p_wr_n` with `p_sel`=1 and `obuf_empty`=1 stores `p_data` in the output buffer and drops `obuf_empty`. A host read at address 0 returns that byte on `h_dout`, and `obuf_empty` returns to 1 within four clocks of that read strobe's falling edge.
- R4: A host write at address 0 with `ibuf_full`=0 stores `h_din` and raises `ibuf_full` within four clocks. A peripheral read falling edge with `p_sel`=1 lowers `ibuf_full` within four clocks.
- R5: A host read at address 1 returns status on `h_dout`: bit 0 = `obuf_empty`, bit 1 = `ibuf_full`, bit 2 = error (1 while `p_err_n` is 0), bits 7:3 = 0.
- R6: A host write at address 0 while `ibuf_full`=1, or a peripheral write while `obuf_empty`=0, drives `p_err_n` low and discards the byte. The stored byte is unchanged.
- R7: The falling edge of a host read at address 1 returns `p_err_n` to 1. The status value already on the bus during that read still shows the error.
- R8: A host write at address 1 with bit 0 = 1 holds `p_reset_n` low for exactly 16 clock cycles. When the pulse ends, `obuf_empty`=1, `ibuf_full`=0 and `p_err_n`=1. The same write with bit 0 = 0 has no effect.
- R9: Each strobe acts once per falling edge, however long it is held low. A host data write held low for 20 cycles into an empty mailbox does not raise an error.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock |
| rst_n | input | 1 | Asynchronous active-low reset |
| h_cs_n | input | 1 | Host chip select, active low |
| h_rd_n | input | 1 | Host read strobe, active low |
| h_wr_n | input | 1 | Host write strobe, active low |
| h_addr | input | 1 | 0 = data mailbox, 1 = status/control |
| h_din | input | 8 | Host write data |
| h_dout | output | 8 | Host read data (status or output-buffer byte) |
| p_sel | input | 1 | Peripheral-side select, active high |
| p_rd_n | input | 1 | Peripheral read strobe, active low |
| p_wr_n | input | 1 | Peripheral write strobe, active low |
| p_data | inout | 8 | Bidirectional peripheral data bus |
| obuf_empty | output | 1 | Output buffer may take another byte |
| ibuf_full | output | 1 | A host byte waits for the peripheral |
| p_reset_n | output | 1 | Reset pulse toward the peripheral, active low |
| p_err_n | output | 1 | Overrun error, active low |

## Verification
The assertions assume that each strobe stays low for at least three clocks, and that address, host data and peripheral data stay stable for that whole time. They also assume that the peripheral never drives `p_data` while it is reading, and that no strobe arrives during a reset pulse. The bench's tasks drive one strobe at a time and hold it low for four clocks with the data already set up. They drive the bus only inside a peripheral write and release it before any read. The reset pulse is measured by a scenario that issues no other traffic until the pulse has ended.

// File: rtl/hostmbox_bridge.sv
module hostmbox_bridge #(
  parameter int DW         = 8,
  parameter int RST_CYCLES = 16
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          h_cs_n,
  input  logic          h_rd_n,
  input  logic          h_wr_n,
  input  logic          h_addr,
  input  logic [DW-1:0] h_din,
  output logic [DW-1:0] h_dout,
  input  logic          p_sel,
  input  logic          p_rd_n,
  input  logic          p_wr_n,
  inout  wire  [DW-1:0] p_data,
  output logic          obuf_empty,
  output logic          ibuf_full,
  output logic          p_reset_n,
  output logic          p_err_n
);
  localparam int CW = $clog2(RST_CYCLES + 1);
  localparam int NS = 4;

  logic [NS-1:0] act;
  logic [2:0]    sync [NS];
  logic [NS-1:0] evt;

  assign act = {p_sel & ~p_wr_n, p_sel & ~p_rd_n, ~h_cs_n & ~h_wr_n, ~h_cs_n & ~h_rd_n};

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) for (int i = 0; i < NS; i++) sync[i] <= '0;
    else        for (int i = 0; i < NS; i++) sync[i] <= {sync[i][1:0], act[i]};

  for (genvar g = 0; g < NS; g++) begin : g_edge
    assign evt[g] = sync[g][1] & ~sync[g][2];
  end

  logic hrd, hwr, prd, pwr;
  assign hrd = evt[0];
  assign hwr = evt[1];
  assign prd = evt[2];
  assign pwr = evt[3];

  logic [DW-1:0] ibuf, obuf;
  logic          err;
  logic [CW-1:0] rcnt;
  logic          rdone;

  assign rdone = (rcnt == CW'(1));

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) rcnt <= '0;
    else if (hwr && h_addr && h_din[0]) rcnt <= CW'(RST_CYCLES);
    else if (rcnt != '0) rcnt <= rcnt - CW'(1);

  always_ff @(posedge clk or negedge rst_n)
    if (!rst_n) begin
      ibuf <= '0; obuf <= '0;
      ibuf_full <= 1'b0; obuf_empty <= 1'b1; err <= 1'b0;
    end else if (rdone) begin
      ibuf_full <= 1'b0; obuf_empty <= 1'b1; err <= 1'b0;
    end else begin
      if (hwr && !h_addr) begin
        if (ibuf_full) err <= 1'b1;
        else begin ibuf <= h_din; ibuf_full <= 1'b1; end
      end else if (prd) ibuf_full <= 1'b0;
      if (pwr) begin
        if (!obuf_empty) err <= 1'b1;
        else begin obuf <= p_data; obuf_empty <= 1'b0; end
      end else if (hrd && !h_addr) obuf_empty <= 1'b1;
      if (hrd && h_addr && !(hwr && !h_addr && ibuf_full) && !(pwr && !obuf_empty)) err <= 1'b0;
    end

  assign p_reset_n = (rcnt == '0);
  assign p_err_n   = ~err;
  assign h_dout    = h_addr ? {{(DW-3){1'b0}}, err, ibuf_full, obuf_empty} : obuf;
  assign p_data    = (p_sel && !p_rd_n) ? ibuf : {DW{1'bz}};

  a_r3_pwr_fills: assert property (@(posedge clk) disable iff (!rst_n)
    pwr && obuf_empty && p_reset_n |=> !obuf_empty);
  a_r3_hrd_drains: assert property (@(posedge clk) disable iff (!rst_n)
    hrd && !h_addr && !pwr |=> obuf_empty);
  a_r4_prd_drains: assert property (@(posedge clk) disable iff (!rst_n)
    prd && !(hwr && !h_addr) |=> !ibuf_full);
  a_r6_host_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    hwr && !h_addr && ibuf_full && p_reset_n |=> !p_err_n && $stable(ibuf));
  a_r6_per_overrun: assert property (@(posedge clk) disable iff (!rst_n)
    pwr && !obuf_empty && p_reset_n |=> !p_err_n && $stable(obuf));
  a_r8_pulse_clears: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(p_reset_n) |-> obuf_empty && !ibuf_full && p_err_n);
  a_r9_single_action: assert property (@(posedge clk) disable iff (!rst_n)
    $past(hwr) |-> !hwr);
endmodule

// File: tb/hostmbox_bridge_test.sv
module hostmbox_bridge_test;
  localparam int CLK_PERIOD = 10;

  logic clk = 0, rst_n = 0;
  logic h_cs_n = 1, h_rd_n = 1, h_wr_n = 1, h_addr = 0;
  logic [7:0] h_din = 0, h_dout;
  logic p_sel = 0, p_rd_n = 1, p_wr_n = 1;
  logic [7:0] p_drv = 0;
  logic p_drv_en = 0;
  wire  [7:0] p_data;
  logic obuf_empty, ibuf_full, p_reset_n, p_err_n;
  int checks = 0, fails = 0;

  assign p_data = p_drv_en ? p_drv : 8'hzz;
  always #(CLK_PERIOD/2) clk = ~clk;

  hostmbox_bridge uut (.clk, .rst_n, .h_cs_n, .h_rd_n, .h_wr_n, .h_addr, .h_din, .h_dout,
    .p_sel, .p_rd_n, .p_wr_n, .p_data, .obuf_empty, .ibuf_full, .p_reset_n, .p_err_n);

  task automatic chk(string req, logic [7:0] act, logic [7:0] exp);
    checks++;
    if (act !== exp) begin
      fails++;
      $display("FAIL %s actual=%h expected=%h", req, act, exp);
    end
  endtask

  task automatic idle(int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic host_wr(logic a, logic [7:0] d, int hold = 4);
    @(negedge clk); h_addr = a; h_din = d; h_cs_n = 0; h_wr_n = 0;
    idle(hold); h_wr_n = 1; h_cs_n = 1; idle(4);
  endtask

  task automatic host_rd(logic a, output logic [7:0] d);
    @(negedge clk); h_addr = a; h_cs_n = 0; h_rd_n = 0;
    #1 d = h_dout;
    idle(4); h_rd_n = 1; h_cs_n = 1; idle(4);
  endtask

  task automatic per_wr(logic [7:0] d);
    @(negedge clk); p_drv = d; p_drv_en = 1; p_sel = 1; p_wr_n = 0;
    idle(4); p_wr_n = 1; p_sel = 0; #1 p_drv_en = 0; idle(4);
  endtask

  task automatic per_rd(logic sel, output logic [7:0] d);
    @(negedge clk); p_sel = sel; p_rd_n = 0;
    #1 d = p_data;
    idle(4); p_rd_n = 1; p_sel = 0; idle(4);
  endtask

  task automatic t_reset_state();
    chk("R1 obuf_empty", obuf_empty, 1); chk("R1 ibuf_full", ibuf_full, 0);
    chk("R1 p_err_n", p_err_n, 1); chk("R1 p_reset_n", p_reset_n, 1);
    chk("R1 p_data", p_data, 8'hzz);
  endtask

  task automatic t_host_to_per();
    logic [7:0] d;
    host_wr(0, 8'hA5);
    chk("R4 full after write", ibuf_full, 1);
    chk("R2 bus idle", p_data, 8'hzz);
    per_rd(0, d);
    chk("R2 unselected read not driven", d, 8'hzz);
    chk("R2 unselected read keeps full", ibuf_full, 1);
    host_rd(1, d);
    chk("R5 status full", d, 8'b0000_0011);
    per_rd(1, d);
    chk("R2 read drives byte", d, 8'hA5);
    chk("R4 full cleared", ibuf_full, 0);
    chk("R2 bus released", p_data, 8'hzz);
  endtask

  task automatic t_per_to_host();
    logic [7:0] d;
    per_wr(8'h3C);
    chk("R3 empty dropped", obuf_empty, 0);
    host_rd(1, d);
    chk("R5 status not empty", d, 8'b0000_0000);
    host_rd(0, d);
    chk("R3 host data", d, 8'h3C);
    chk("R3 empty restored", obuf_empty, 1);
  endtask

  task automatic t_overrun();
    logic [7:0] d;
    host_wr(0, 8'h11);
    host_wr(0, 8'h22);
    chk("R6 host overrun err", p_err_n, 0);
    host_rd(1, d);
    chk("R7 status shows err", d, 8'b0000_0111);
    chk("R7 err cleared", p_err_n, 1);
    per_rd(1, d);
    chk("R6 first byte kept", d, 8'h11);
    per_wr(8'h44);
    per_wr(8'h55);
    chk("R6 per overrun err", p_err_n, 0);
    host_rd(0, d);
    chk("R6 first per byte kept", d, 8'h44);
    host_rd(1, d);
    chk("R7 status err after drain", d, 8'b0000_0101);
    chk("R7 err cleared again", p_err_n, 1);
  endtask

  task automatic t_long_strobe();
    logic [7:0] d;
    host_wr(0, 8'h77, 20);
    chk("R9 no error on long strobe", p_err_n, 1);
    chk("R9 full once", ibuf_full, 1);
    per_rd(1, d);
    chk("R9 byte", d, 8'h77);
  endtask

  task automatic t_periph_reset();
    int low = 0;
    host_wr(1, 8'h00);
    chk("R8 bit0 clear no pulse", p_reset_n, 1);
    host_wr(0, 8'h99);
    per_wr(8'h66);
    per_wr(8'h67);
    chk("R8 setup err", p_err_n, 0);
    @(negedge clk); h_addr = 1; h_din = 8'h01; h_cs_n = 0; h_wr_n = 0;
    for (int i = 0; i < 40; i++) begin
      @(negedge clk);
      if (i == 3) begin h_wr_n = 1; h_cs_n = 1; end
      if (!p_reset_n) low++;
    end
    chk("R8 pulse length", 8'(low), 8'd16);
    chk("R8 empty after", obuf_empty, 1);
    chk("R8 full after", ibuf_full, 0);
    chk("R8 err after", p_err_n, 1);
  endtask

  initial begin
    fork
      begin
        idle(3); rst_n = 1; idle(2);
        t_reset_state();
        t_host_to_per();
        t_per_to_host();
        t_overrun();
        t_long_strobe();
        t_periph_reset();
      end
      begin
        repeat (20000) @(posedge clk);
        checks++; fails++;
        $display("FAIL watchdog actual=timeout expected=done");
      end
    join_any
    disable fork;
    $display("%0d/%0d checks passed", checks - fails, checks);
    $finish;
  end
endmodule